// File: doc/BRIEF.md
# Register-Pair and Stack Sequencer

This block holds the programmer-visible pointer state of a small 8-bit processor. It has six byte registers that combine into three 16-bit pairs, a 16-bit stack pointer and a 16-bit program counter. A decoder outside the block issues one command code per cycle. The block either updates its registers in that cycle or starts a two-byte stack transfer over a byte-wide memory port.

Stack writes always move the pointer down before storing a byte. Stack reads always take the byte first and then move the pointer up. The more significant byte of a 16-bit value sits at the higher address. Saving the program counter for a subroutine call and restoring it on return reuse the same two-cycle byte sequences. While no stack transfer is running, the memory address port shows the program counter, which serves as the instruction fetch address.

Top module: `stack_pair_seq`

## Requirements
- R1: After reset the program counter, the stack pointer and all six byte registers are zero. `mem_we` and `done` are low, and `mem_addr` shows the program counter (0000h).
- R2: Command 001 (fetch) adds one to the program counter modulo 65536. While idle, `mem_addr` always equals the program counter.
- R3: Command 010 (load) writes `ld_data` into the pair chosen by `sel`: 00 = B:C, 01 = D:E, 10 = H:L, 11 = stack pointer. B, D and H hold bits 15:8 of the pair.
- R4: Command 011 (jump) replaces the program counter with `ld_data`.
- R5: Command 100 (push) takes two cycles, both with `mem_we` high. The first cycle writes bits 15:8 of the selected pair at SP-1. The second writes bits 7:0 at SP-2. The stack pointer ends at SP-2.
- R6: Command 101 (pop) takes two cycles with `mem_we` low. Bits 7:0 are read from SP, then bits 15:8 from SP+1, and the stack pointer ends at SP+2. With `sel` = 11 the stack pointer takes the popped value instead.
- R7: Command 110 (call or restart) pushes the current program counter in the same way as R5 and then loads the program counter with `ld_data`.
- R8: Command 111 (return) pops two bytes in the same way as R6 into the program counter.
- R9: `done` is high for exactly one cycle: the cycle in which the second byte of a stack transfer is moved.
- R10: Any command presented while a stack transfer is in progress is ignored.
- R11: Stack pointer arithmetic wraps modulo 65536. A push from SP = 0000h writes FFFFh and then FFFEh.
- R12: Outside push and call write cycles, `mem_we` is low and `mem_wdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command code, sampled only when idle |
| sel | input | 2 | Pair select for load, push and pop |
| ld_data | input | 16 | Load value or jump/call target |
| mem_rdata | input | 8 | Memory read data, combinational from `mem_addr` |
| mem_addr | output | 16 | Stack address while busy, program counter while idle |
| mem_wdata | output | 8 | Byte being written to the stack |
| mem_we | output | 1 | Memory write strobe |
| done | output | 1 | Pulses in the final byte cycle of a stack transfer |

## Verification
The bench goes after byte order and pointer ordering.
- A design that writes before decrementing, or that stores the low byte first, puts the pushed byte on the wrong address. The bench catches this because it compares the exact write address and data in each cycle.
- A pop that increments before reading returns a shifted value. Each popped pair is pushed out again, so a swapped or shifted value becomes visible at the write port.

The bench also pushes from SP = 0000h and fetches across FFFFh, which exposes pointers that saturate instead of wrapping. It pops into the stack pointer itself, which exposes a design where the increment overrides the loaded value. It drives a jump command on every busy cycle, so a design that does not ignore commands while busy leaves the wrong program counter on the idle address.

// File: rtl/stack_pair_seq.sv
module stack_pair_seq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cmd,
  input  logic [1:0]      sel,
  input  logic [2*DW-1:0] ld_data,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            done
);
  localparam int PW = 2 * DW;
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  localparam logic [2:0] C_FETCH = 3'd1, C_LOAD = 3'd2, C_JUMP = 3'd3, C_PUSH = 3'd4,
                         C_POP = 3'd5, C_CALL = 3'd6, C_RET = 3'd7;
  localparam logic [2:0] S_IDLE = 3'd0, S_PSH1 = 3'd1, S_PSH2 = 3'd2,
                         S_POP1 = 3'd3, S_POP2 = 3'd4;

  logic [DW-1:0] rf [6];
  logic [PW-1:0] pc, sp, hold, tgt;
  logic [2:0]    st;
  logic [1:0]    dsel;
  logic          to_pc;

  wire pushing = (st == S_PSH1) || (st == S_PSH2);
  wire popping = (st == S_POP1) || (st == S_POP2);
  wire [PW-1:0] sp_dn = sp - ONE;
  wire [PW-1:0] sp_up = sp + ONE;
  wire [PW-1:0] popped = {mem_rdata, hold[DW-1:0]};

  logic [PW-1:0] sel_val;
  always_comb begin
    case (sel)
      2'd0:    sel_val = {rf[0], rf[1]};
      2'd1:    sel_val = {rf[2], rf[3]};
      2'd2:    sel_val = {rf[4], rf[5]};
      default: sel_val = sp;
    endcase
  end

  assign mem_addr  = pushing ? sp_dn : (popping ? sp : pc);
  assign mem_we    = pushing;
  assign mem_wdata = (st == S_PSH1) ? hold[PW-1:DW] :
                     (st == S_PSH2) ? hold[DW-1:0] : '0;
  assign done      = (st == S_PSH2) || (st == S_POP2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) rf[i] <= '0;
      pc    <= '0;
      sp    <= '0;
      hold  <= '0;
      tgt   <= '0;
      st    <= S_IDLE;
      dsel  <= '0;
      to_pc <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          case (cmd)
            C_FETCH: pc <= pc + ONE;
            C_LOAD: begin
              if (sel == 2'd3) sp <= ld_data;
              else begin
                rf[{sel, 1'b0}] <= ld_data[PW-1:DW];
                rf[{sel, 1'b1}] <= ld_data[DW-1:0];
              end
            end
            C_JUMP: pc <= ld_data;
            C_PUSH: begin
              hold  <= sel_val;
              to_pc <= 1'b0;
              st    <= S_PSH1;
            end
            C_POP: begin
              dsel  <= sel;
              to_pc <= 1'b0;
              st    <= S_POP1;
            end
            C_CALL: begin
              hold  <= pc;
              tgt   <= ld_data;
              to_pc <= 1'b1;
              st    <= S_PSH1;
            end
            C_RET: begin
              to_pc <= 1'b1;
              st    <= S_POP1;
            end
            default: ;
          endcase
        end
        S_PSH1: begin
          sp <= sp_dn;
          st <= S_PSH2;
        end
        S_PSH2: begin
          sp <= sp_dn;
          st <= S_IDLE;
          if (to_pc) pc <= tgt;
        end
        S_POP1: begin
          hold[DW-1:0] <= mem_rdata;
          sp <= sp_up;
          st <= S_POP2;
        end
        S_POP2: begin
          st <= S_IDLE;
          sp <= sp_up;
          if (to_pc) pc <= popped;
          else if (dsel == 2'd3) sp <= popped;
          else begin
            rf[{dsel, 1'b0}] <= mem_rdata;
            rf[{dsel, 1'b1}] <= hold[DW-1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module stack_pair_seq_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd,
  input logic [2:0]    st,
  input logic [PW-1:0] mem_addr,
  input logic          mem_we,
  input logic          done
);
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1) |=> (mem_we && done && mem_addr == $past(mem_addr) - ONE));
  // R6
  pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |=> (!mem_we && done && mem_addr == $past(mem_addr) + ONE));
  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && cmd == 3'd1) |=> (st == 3'd0 && mem_addr == $past(mem_addr) + ONE));
  // R12
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !mem_we);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1) |=> (st == 3'd2));
endmodule

bind stack_pair_seq stack_pair_seq_chk #(.PW(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .st(st),
  .mem_addr(mem_addr), .mem_we(mem_we), .done(done)
);

// File: tb/stack_pair_seq_test.sv
`timescale 1ns/1ps
module stack_pair_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] sel = 2'd0;
  logic [15:0] ld_data = 16'h0;
  logic [7:0] mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_we, done;

  always #2.5 clk = ~clk;

  stack_pair_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(sel), .ld_data(ld_data),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .done(done)
  );

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  logic [15:0] m_pair [4];
  logic [15:0] m_pc;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cmd(logic [2:0] c, logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    cmd = c; sel = s; ld_data = d;
    @(negedge clk);
    cmd = 3'd0;
    case (c)
      3'd1: m_pc = m_pc + 16'd1;
      3'd2: m_pair[s] = d;
      3'd3: m_pc = d;
      default: ;
    endcase
    chk("R2/R4 idle address is PC", mem_addr, m_pc);
  endtask

  task automatic push_seq(bit is_call, logic [1:0] s, logic [15:0] target);
    logic [15:0] val, sp0;
    val = is_call ? m_pc : m_pair[s];
    sp0 = m_pair[3];
    @(negedge clk);
    cmd = is_call ? 3'd6 : 3'd4; sel = s; ld_data = target;
    @(negedge clk);
    cmd = 3'd3; ld_data = 16'hDEAD;
    chk("R5/R11 first push address", mem_addr, sp0 - 16'd1);
    chk("R3/R5/R7 high byte data", {8'h0, mem_wdata}, {8'h0, val[15:8]});
    chk("R5 write strobe 1", {15'h0, mem_we}, 16'd1);
    chk("R9 done low in first byte", {15'h0, done}, 16'd0);
    @(negedge clk);
    chk("R5/R11 second push address", mem_addr, sp0 - 16'd2);
    chk("R3/R5/R7 low byte data", {8'h0, mem_wdata}, {8'h0, val[7:0]});
    chk("R5 write strobe 2", {15'h0, mem_we}, 16'd1);
    chk("R9 done high in second byte", {15'h0, done}, 16'd1);
    m_pair[3] = sp0 - 16'd2;
    if (is_call) m_pc = target;
    @(negedge clk);
    cmd = 3'd0;
    chk("R9 done one cycle", {15'h0, done}, 16'd0);
    chk("R12 idle strobe", {15'h0, mem_we}, 16'd0);
    chk("R12 idle data", {8'h0, mem_wdata}, 16'd0);
    chk("R7/R10 PC after push", mem_addr, m_pc);
  endtask

  task automatic pop_seq(bit is_ret, logic [1:0] s);
    logic [15:0] sp0, sp1, exp;
    sp0 = m_pair[3];
    sp1 = sp0 + 16'd1;
    exp = {mem[sp1[7:0]], mem[sp0[7:0]]};
    @(negedge clk);
    cmd = is_ret ? 3'd7 : 3'd5; sel = s;
    @(negedge clk);
    cmd = 3'd3; ld_data = 16'hBEEF;
    chk("R6 first pop address", mem_addr, sp0);
    chk("R6 no write in pop", {15'h0, mem_we}, 16'd0);
    chk("R9 done low first pop byte", {15'h0, done}, 16'd0);
    @(negedge clk);
    chk("R6 second pop address", mem_addr, sp1);
    chk("R9 done high second pop byte", {15'h0, done}, 16'd1);
    m_pair[3] = sp0 + 16'd2;
    if (is_ret) m_pc = exp;
    else m_pair[s] = exp;
    @(negedge clk);
    cmd = 3'd0;
    chk("R9 done one cycle after pop", {15'h0, done}, 16'd0);
    chk("R8/R10 PC after pop", mem_addr, m_pc);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 4; i++) m_pair[i] = 16'h0;
    m_pc = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 reset address", mem_addr, 16'h0);
    chk("R1 reset strobe", {15'h0, mem_we}, 16'd0);
    chk("R1 reset done", {15'h0, done}, 16'd0);
    rst_n = 1'b1;
    // R1 zero registers, R11 wrap from SP=0000
    push_seq(1'b0, 2'd0, 16'h0);
    push_seq(1'b0, 2'd2, 16'h0);
    for (int i = 0; i < 20; i++) idle_cmd(3'd1, 2'd0, 16'h0);
    idle_cmd(3'd3, 2'd0, 16'hFFFE);
    idle_cmd(3'd1, 2'd0, 16'h0);
    idle_cmd(3'd1, 2'd0, 16'h0);
    chk("R2 PC wraps to 0000", mem_addr, 16'h0000);
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 6; k++) begin
        logic [1:0] q;
        q = 2'((p + 1) % 3);
        idle_cmd(3'd2, 2'(p), 16'(p * 16'h1111 ^ k * 16'h2357 + 16'h0F0F));
        idle_cmd(3'd2, 2'd3, 16'(16'h2099 + k * 6));
        push_seq(1'b0, 2'(p), 16'h0);
        pop_seq(1'b0, q);
        push_seq(1'b0, q, 16'h0);
      end
    end
    // R6 pop into the stack pointer itself
    idle_cmd(3'd2, 2'd2, 16'h5A31);
    idle_cmd(3'd2, 2'd3, 16'h2040);
    push_seq(1'b0, 2'd2, 16'h0);
    pop_seq(1'b0, 2'd3);
    chk("R6 SP loaded from pop", m_pair[3], 16'h5A31);
    push_seq(1'b0, 2'd0, 16'h0);
    // R7 call, R8 return
    idle_cmd(3'd3, 2'd0, 16'h1234);
    idle_cmd(3'd2, 2'd3, 16'h20A0);
    push_seq(1'b1, 2'd0, 16'h4000);
    chk("R7 call target", mem_addr, 16'h4000);
    idle_cmd(3'd1, 2'd0, 16'h0);
    pop_seq(1'b1, 2'd0);
    chk("R8 return address", mem_addr, 16'h1234);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule